// File: doc/BRIEF.md
# Exposure and Gain Frame-Aligned Update Unit

This unit sits between a register bus and the pixel array controller of an image sensor. Software writes new integration settings byte by byte into a small exposure page: a coarse exposure in whole lines, a fine exposure in extra pixel clocks, and a three-bit amplifier gain code. The unit holds those bytes in a staging area. It passes them to the array only at a frame boundary, so the array never sees a setting change partway through a frame.

Out-of-range exposure values are limited to the nearest legal value instead of being refused. The fine limit depends on the frame-rate mode, because a line lasts 393 pixel periods at 30 fps and 471 at 25 fps. Exposure results only show up in the read-out one frame after they are applied. For that reason the gain that accompanies an exposure is applied one frame boundary later, so that both take effect on the same output frame.

A level input marks a bus transaction to the page as in progress. While it is high, every frame boundary is held back and then taken as soon as the level drops. A multi-byte update is therefore never split across two frames. A status flag shows that staged values are still waiting to be applied.

Top module: `expgain_retimer`

## Requirements
- R1: During and directly after a synchronous reset, coarse_q, fine_q and gain_q are 0 and update_pending is 0.
- R2: Page offsets are: 0 coarse high byte, 1 coarse low byte, 2 fine high byte, 3 fine low byte, 4 gain in bits [2:0]. The applied coarse value is the 16-bit {high, low} staged value, limited to at most 302.
- R3: The applied fine value is the 16-bit {high, low} staged value, limited to at most 356 or at most 434. The limit is 434 when rate_25 was 1 during the most recent write to offset 2 or 3, and 356 otherwise (including after reset).
- R4: An apply event happens on a clock edge where page_busy is 0 and either frame_start is 1 or a deferred boundary is held. The outputs take their new values right after that edge, and they do not change after any other edge.
- R5: update_pending becomes 1 after a clock edge that samples a write to offsets 0..4. It returns to 0 after an apply event. If a page write and an apply event fall on the same edge, it stays 1.
- R6: The gain code staged at one apply event appears on gain_q at the next apply event, one boundary after the exposure it was written with.
- R7: A frame_start sampled while page_busy is 1 is deferred. One apply event occurs on the first edge that samples page_busy at 0, however many strobes arrived while it was high. Outputs stay unchanged while page_busy is sampled high.
- R8: Writes to offsets 5..7 change no staged value and do not set update_pending.
- R9: The gain code is passed through without change; 000, 001, 011 and 111 select gains of x1, x2, x4 and x8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe for the exposure page |
| wr_addr | input | 3 | Page offset of the write |
| wr_data | input | 8 | Write data byte |
| page_busy | input | 1 | High for the whole of a bus transaction to the page |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| rate_25 | input | 1 | 1 selects 25 fps, 0 selects 30 fps |
| coarse_q | output | 9 | Applied coarse exposure in lines |
| fine_q | output | 9 | Applied fine exposure in pixel clocks |
| gain_q | output | 3 | Applied gain code |
| update_pending | output | 1 | Staged values are not yet applied |

## Verification
The bench aims at the clipping edges: values just above each limit, the high byte set alone, and a fine value written in one frame-rate mode and applied after the mode has changed. A unit that clipped with the current mode, or not at all, would apply a value above the range. Boundaries that arrive during a transaction, and repeated strobes within one transaction, are checked. Splitting an update or applying twice would show up as outputs that change under page_busy or change again later. A write on the same edge as an apply event is also checked. Dropping the pending flag in that case, or delaying gain by zero or two boundaries, would show as a pending or gain mismatch against the cycle model.

// File: rtl/expgain_pkg.sv
package expgain_pkg;

    localparam int BYTE_W     = 8;
    localparam int RAW_W      = 2 * BYTE_W;
    localparam int ADDR_W     = 3;
    localparam int COARSE_W   = 9;
    localparam int FINE_W     = 9;
    localparam int GAIN_W     = 3;
    localparam int PAGE_SLOTS = 5;

    localparam int COARSE_LIMIT  = 302;
    localparam int FINE_LIMIT_30 = 356;
    localparam int FINE_LIMIT_25 = 434;

    // offsets in the exposure page
    localparam logic [ADDR_W-1:0] OFS_COARSE_HI = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_COARSE_LO = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_FINE_HI   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_FINE_LO   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_GAIN      = 3'd4;

    typedef enum logic {
        BND_IDLE = 1'b0,
        BND_HELD = 1'b1
    } bnd_state_e;

    typedef struct packed {
        logic [RAW_W-1:0]  coarse_raw;
        logic [RAW_W-1:0]  fine_raw;
        logic              fine_slow;   // mode captured at fine write
        logic [GAIN_W-1:0] gain;
    } staged_t;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } expo_t;

    function automatic logic [RAW_W-1:0] clip_to(input logic [RAW_W-1:0] value,
                                                 input logic [RAW_W-1:0] limit);
        return (value > limit) ? limit : value;
    endfunction

endpackage

// File: rtl/expgain_stage.sv
module expgain_stage
    import expgain_pkg::*;
#(
    parameter int N_SLOTS = PAGE_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rate_slow,
    output staged_t           stage_o,
    output logic              page_wr_o
);

    localparam logic [ADDR_W-1:0] SLOT_END = ADDR_W'(N_SLOTS);

    staged_t stage_q;

    always_comb begin
        page_wr_o = wr_en && (wr_addr < SLOT_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (page_wr_o) begin
            case (wr_addr)
                OFS_COARSE_HI: stage_q.coarse_raw[RAW_W-1:BYTE_W] <= wr_data;
                OFS_COARSE_LO: stage_q.coarse_raw[BYTE_W-1:0]     <= wr_data;
                OFS_FINE_HI: begin
                    stage_q.fine_raw[RAW_W-1:BYTE_W] <= wr_data;
                    stage_q.fine_slow                <= rate_slow;
                end
                OFS_FINE_LO: begin
                    stage_q.fine_raw[BYTE_W-1:0] <= wr_data;
                    stage_q.fine_slow            <= rate_slow;
                end
                OFS_GAIN:    stage_q.gain <= wr_data[GAIN_W-1:0];
                default:     ;
            endcase
        end
    end

    assign stage_o = stage_q;

endmodule

// File: rtl/expgain_boundary.sv
module expgain_boundary
    import expgain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic busy,
    output logic apply_o
);

    bnd_state_e state_q;
    logic       boundary_seen;

    always_comb begin
        boundary_seen = frame_start || (state_q == BND_HELD);
        apply_o       = boundary_seen && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BND_IDLE;
        end else if (busy && boundary_seen) begin
            state_q <= BND_HELD;
        end else begin
            state_q <= BND_IDLE;
        end
    end

endmodule

// File: rtl/expgain_apply.sv
module expgain_apply
    import expgain_pkg::*;
#(
    parameter int GAIN_LAG = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                apply,
    input  logic                page_wr,
    input  staged_t             stage,
    output logic [COARSE_W-1:0] coarse_o,
    output logic [FINE_W-1:0]   fine_o,
    output logic [GAIN_W-1:0]   gain_o,
    output logic                pending_o
);

    localparam logic [RAW_W-1:0] C_LIM  = RAW_W'(COARSE_LIMIT);
    localparam logic [RAW_W-1:0] F_LIM0 = RAW_W'(FINE_LIMIT_30);
    localparam logic [RAW_W-1:0] F_LIM1 = RAW_W'(FINE_LIMIT_25);

    expo_t            next_expo;
    expo_t            expo_q;
    logic [RAW_W-1:0] coarse_cl;
    logic [RAW_W-1:0] fine_cl;
    logic [GAIN_W-1:0] lag_q [GAIN_LAG];
    logic [GAIN_W-1:0] gain_q;
    logic              pending_q;

    always_comb begin
        coarse_cl        = clip_to(stage.coarse_raw, C_LIM);
        fine_cl          = clip_to(stage.fine_raw, stage.fine_slow ? F_LIM1 : F_LIM0);
        next_expo.coarse = coarse_cl[COARSE_W-1:0];
        next_expo.fine   = fine_cl[FINE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expo_q <= '0;
        end else if (apply) begin
            expo_q <= next_expo;
        end
    end

    // gain delay line, one stage per boundary of lag
    generate
        for (genvar gi = 0; gi < GAIN_LAG; gi++) begin : g_lag
            always_ff @(posedge clk) begin
                if (rst) begin
                    lag_q[gi] <= '0;
                end else if (apply) begin
                    if (gi == 0) begin
                        lag_q[gi] <= stage.gain;
                    end else begin
                        lag_q[gi] <= lag_q[(gi == 0) ? 0 : gi-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= '0;
        end else if (apply) begin
            gain_q <= lag_q[GAIN_LAG-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
        end else if (page_wr) begin
            pending_q <= 1'b1;
        end else if (apply) begin
            pending_q <= 1'b0;
        end
    end

    assign coarse_o  = expo_q.coarse;
    assign fine_o    = expo_q.fine;
    assign gain_o    = gain_q;
    assign pending_o = pending_q;

    AST_COARSE_CEIL: assert property (@(posedge clk) disable iff (rst)
        coarse_o <= COARSE_W'(COARSE_LIMIT)); // R2
    AST_FINE_CEIL: assert property (@(posedge clk) disable iff (rst)
        fine_o <= FINE_W'(FINE_LIMIT_25)); // R3
    AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable({coarse_o, fine_o, gain_o})); // R4
    AST_PENDING_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        page_wr |=> pending_o); // R5
    AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (apply && !page_wr) |=> !pending_o); // R5

endmodule

// File: rtl/expgain_retimer.sv
module expgain_retimer
    import expgain_pkg::*;
#(
    parameter int GAIN_LAG = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                page_busy,
    input  logic                frame_start,
    input  logic                rate_25,
    output logic [COARSE_W-1:0] coarse_q,
    output logic [FINE_W-1:0]   fine_q,
    output logic [GAIN_W-1:0]   gain_q,
    output logic                update_pending
);

    staged_t stage;
    logic    page_wr;
    logic    apply;

    expgain_stage #(.N_SLOTS(PAGE_SLOTS)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rate_slow (rate_25),
        .stage_o   (stage),
        .page_wr_o (page_wr)
    );

    expgain_boundary u_bnd (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .busy        (page_busy),
        .apply_o     (apply)
    );

    expgain_apply #(.GAIN_LAG(GAIN_LAG)) u_apply (
        .clk       (clk),
        .rst       (rst),
        .apply     (apply),
        .page_wr   (page_wr),
        .stage     (stage),
        .coarse_o  (coarse_q),
        .fine_o    (fine_q),
        .gain_o    (gain_q),
        .pending_o (update_pending)
    );

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        page_busy |=> $stable({coarse_q, fine_q, gain_q})); // R7
    AST_IGNORED_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= ADDR_W'(PAGE_SLOTS) && !update_pending) |=> !update_pending); // R8

endmodule

// File: tb/expgain_retimer_tb_top.sv
module expgain_retimer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       page_busy = 1'b0;
    logic       frame_start = 1'b0;
    logic       rate_25 = 1'b0;
    logic [8:0] coarse_q;
    logic [8:0] fine_q;
    logic [2:0] gain_q;
    logic       update_pending;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int s_ch, s_cl, s_fh, s_fl, s_g;
    bit s_slow;
    int m_c, m_f, m_mid, m_g;
    bit m_pend, m_held;

    always #4 clk = ~clk;

    expgain_retimer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_busy(page_busy), .frame_start(frame_start), .rate_25(rate_25),
        .coarse_q(coarse_q), .fine_q(fine_q), .gain_q(gain_q),
        .update_pending(update_pending)
    );

    function automatic int lim(int v, int l);
        return (v > l) ? l : v;
    endfunction

    always @(posedge clk) begin
        bit app;
        started = 1;
        if (rst) begin
            s_ch = 0; s_cl = 0; s_fh = 0; s_fl = 0; s_g = 0; s_slow = 0;
            m_c = 0; m_f = 0; m_mid = 0; m_g = 0; m_pend = 0; m_held = 0;
        end else begin
            app    = !page_busy && (frame_start || m_held);
            m_held = page_busy && (frame_start || m_held);
            if (app) begin
                m_c    = lim(s_ch * 256 + s_cl, 302);
                m_f    = lim(s_fh * 256 + s_fl, s_slow ? 434 : 356);
                m_g    = m_mid;
                m_mid  = s_g;
                m_pend = 0;
            end
            if (wr_en && wr_addr < 5) begin
                m_pend = 1;
                case (wr_addr)
                    3'd0: s_ch = wr_data;
                    3'd1: s_cl = wr_data;
                    3'd2: begin s_fh = wr_data; s_slow = rate_25; end
                    3'd3: begin s_fl = wr_data; s_slow = rate_25; end
                    default: s_g = wr_data & 8'h07;
                endcase
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            cmp("coarse_q (R2)", int'(coarse_q), m_c);
            cmp("fine_q (R3)", int'(fine_q), m_f);
            cmp("gain_q (R6)", int'(gain_q), m_g);
            cmp("update_pending (R5)", int'(update_pending), int'(m_pend));
        end
    end

    // one cycle of stimulus, applied away from the active edge
    task automatic step(bit w, int a, int d, bit fs);
        @(negedge clk);
        wr_en       = w;
        wr_addr     = 3'(a);
        wr_data     = 8'(d);
        frame_start = fs;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic page_update(int c, int f, int g);
        @(negedge clk); page_busy = 1;
        step(1, 0, c >> 8, 0);
        step(1, 1, c & 255, 0);
        step(1, 2, f >> 8, 0);
        step(1, 3, f & 255, 0);
        step(1, 4, g, 0);
        step(0, 0, 0, 0);
        page_busy = 0;
    endtask

    task automatic frame();
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        idle(2);
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        @(negedge clk); rst = 0;
        idle(3);

        cur_req = "R2";
        page_update(100, 200, 1);
        idle(3);
        frame();
        cur_req = "R6";
        frame();

        cur_req = "R2";
        page_update(16'h0200, 300, 3);
        frame();
        page_update(303, 300, 3);
        frame();

        cur_req = "R3";
        rate_25 = 0;
        page_update(10, 400, 7);
        frame();
        rate_25 = 1;
        page_update(10, 400, 7);
        rate_25 = 0;
        frame();
        rate_25 = 1;
        page_update(10, 16'h01F0, 0);
        frame();
        rate_25 = 0;

        cur_req = "R7";
        @(negedge clk); page_busy = 1;
        step(1, 1, 50, 1);
        step(1, 3, 60, 0);
        step(0, 0, 0, 1);
        step(1, 4, 3, 1);
        idle(3);
        @(negedge clk); page_busy = 0;
        idle(4);
        frame();

        cur_req = "R8";
        step(1, 5, 255, 0);
        step(1, 6, 255, 0);
        step(1, 7, 255, 0);
        idle(2);
        frame();

        cur_req = "R5";
        step(1, 1, 77, 1);
        idle(3);
        frame();

        cur_req = "R9";
        page_update(20, 30, 3);
        frame();
        page_update(21, 31, 7);
        frame();
        frame();

        cur_req = "R4";
        idle(10);
        for (int k = 0; k < 400; k++) begin
            page_busy = ($urandom_range(0, 3) == 0);
            rate_25   = $urandom_range(0, 1);
            step($urandom_range(0, 1), $urandom_range(0, 7),
                 $urandom_range(0, 255), ($urandom_range(0, 7) == 0));
        end
        page_busy = 0;
        idle(3);
        frame();

        cur_req = "R1";
        @(negedge clk); rst = 1;
        idle(2);
        @(negedge clk); rst = 0;
        idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule